// File: doc/BRIEF.md
# Programmable Chip-Select Channel with Wait-State Acknowledge

This block is one chip-select channel for an external bus in the 68000 style, where a bus master drives an address strobe, a data strobe, a read/write line and a function code. A 16-bit option word sets the conditions under which the channel drives its select. The conditions are the byte lanes, the transfer direction, the address space, an interrupt priority, the strobe used for timing, and asynchronous or E-clock-synchronous operation. Address range decoding sits outside the block, and a single precomputed `addr_hit` input stands in for it.

Once the select is asserted, the channel can terminate the cycle by itself. It returns a data-strobe acknowledge after a programmed number of wait clocks, or at once for fast termination. It can also leave acknowledge to an external device. During a matching interrupt-acknowledge cycle it can request an autovector response. The select, the acknowledge and the autovector request all drop as soon as the address strobe drops.

A parameter builds the channel either as a general channel or as the boot channel. The boot channel comes out of reset already enabled for both lanes, both directions and both privilege spaces.

Top module: `csel_unit`

## Requirements
- R1: After reset `cs_o`, `dsack_o` and `avec_o` are low. On a general channel (`IS_BOOT`=0) the option word resets to all zeros, so no access asserts `cs_o` until the word is written. On the boot channel, the first clock after reset is released loads byte-lane 11, direction 11 and space 11, with every other field zero. An ordinary supervisor read then asserts `cs_o` with one wait clock.
- R2: With a 16-bit port (`port16`=1), lane field 01 enables only the lower lane and 10 enables only the upper lane. The upper lane is used when `bus_a0`=0 or `bus_word`=1. The lower lane is used when `bus_a0`=1 or `bus_word`=1. Lane field 11 enables both lanes. No access asserts `cs_o` while `addr_hit` is low.
- R3: With an 8-bit port (`port16`=0), any nonzero lane field enables the select whatever `bus_a0` and `bus_word` are. Lane field 00 disables the channel.
- R4: Direction field 01 allows reads only (`bus_rd`=1) and 10 allows writes only. Field 11 allows both, and field 00 allows neither.
- R5: `bus_fc`=7 is CPU space. Codes with bit 2 clear are user space, and the other codes are supervisor space. Space field 00 selects CPU space, 01 user, 10 supervisor and 11 either user or supervisor. An access in any other space does not assert `cs_o`.
- R6: In CPU space with space field 00, a priority field of 000 matches any `bus_lvl`. Any other priority field matches only an equal `bus_lvl`.
- R7: In asynchronous mode (mode bit 0), strobe bit 0 lets `cs_o` assert on the first clock edge that sees `bus_as` with a qualified access. Strobe bit 1 makes it wait for `bus_ds` as well.
- R8: In synchronous mode (mode bit 1), `cs_o` asserts only on an edge where `eclk_en` is high and the access is qualified, whatever the strobe bit and `bus_ds` are.
- R9: For acknowledge codes 0 to 13 (N), `dsack_o` first rises N+1 clocks after `cs_o` rises, and it stays high while `cs_o` stays high.
- R10: Acknowledge code 14 (fast termination) raises `dsack_o` in the same cycle as `cs_o`.
- R11: Acknowledge code 15 (external) never raises `dsack_o`.
- R12: `cs_o` and `dsack_o` both fall on the first clock edge that sees `bus_as` low.
- R13: `avec_o` is high together with `cs_o` only when the autovector bit is set, the space field is 00 and the access is in CPU space. Otherwise it stays low.
- R14: The option word is loaded from `opt_wdata` on a clock edge where `opt_we` is high. Its layout is: bit 15 autovector, bit 14 mode, bit 13 strobe, bits 12:11 direction, bits 10:9 lanes, bits 8:7 space, bits 6:4 priority, bits 3:0 acknowledge code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opt_we | input | 1 | Option word write enable |
| opt_wdata | input | 16 | Option word write data |
| bus_as | input | 1 | Address strobe, active high |
| bus_ds | input | 1 | Data strobe, active high |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_fc | input | 3 | Function code (address space) |
| bus_a0 | input | 1 | Address bit 0 |
| bus_word | input | 1 | 1 = word transfer, 0 = byte |
| bus_lvl | input | 3 | Interrupt level of an acknowledge cycle |
| port16 | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| addr_hit | input | 1 | Address range match from the external decoder |
| eclk_en | input | 1 | One-clock pulse marking an E-clock sampling point |
| cs_o | output | 1 | Chip select, active high |
| dsack_o | output | 1 | Internally generated data-strobe acknowledge |
| avec_o | output | 1 | Autovector request |

## Verification
A wrong qualification term, such as a mis-decoded lane, direction, space or priority bit, shows up on `cs_o` at the first sample after the strobe, one clock into the access. A wrong wait counter or acknowledge decode moves the rising edge of `dsack_o` by whole cycles. The bench therefore measures that edge exactly for several codes rather than only checking that it arrives. A select or acknowledge that is held too long is caught one clock after the address strobe drops.

// File: rtl/csel_pkg.sv
package csel_pkg;

   // Option word, MSB first (R14)
   typedef struct packed {
      logic       avec;      // 15
      logic       sync_mode; // 14
      logic       strb_ds;   // 13
      logic [1:0] dir;       // 12:11
      logic [1:0] lanes;     // 10:9
      logic [1:0] space;     // 8:7
      logic [2:0] prio;      // 6:4
      logic [3:0] ack;       // 3:0
   } copt_t;

   localparam int OPT_W = $bits(copt_t);
   localparam int ACK_W = 4;

   localparam logic [1:0] SP_CPU  = 2'b00;
   localparam logic [1:0] SP_USER = 2'b01;
   localparam logic [1:0] SP_SUPV = 2'b10;
   localparam logic [1:0] SP_BOTH = 2'b11;

endpackage

// File: rtl/csel_match.sv
module csel_match #(
   parameter int FC_W  = 3,
   parameter int LVL_W = 3
) (
   input  csel_pkg::copt_t   opt,
   input  logic              bus_rd,
   input  logic [FC_W-1:0]   bus_fc,
   input  logic              bus_a0,
   input  logic              bus_word,
   input  logic [LVL_W-1:0]  bus_lvl,
   input  logic              port16,
   input  logic              addr_hit,
   output logic              cpu_space,
   output logic              qual
);
   import csel_pkg::*;

   localparam logic [FC_W-1:0] FC_CPU = {FC_W{1'b1}};

   generate
      if (FC_W < 3) begin : g_bad_fc
         $error("csel_match: FC_W must be at least 3");
      end
      if (LVL_W != 3) begin : g_bad_lvl
         $error("csel_match: LVL_W must match the priority field");
      end
   endgenerate

   logic lane_up, lane_lo, lane_ok, dir_ok, space_ok, prio_ok, user_sp;

   always_comb begin
      lane_up = ~bus_a0 | bus_word;
      lane_lo =  bus_a0 | bus_word;
      if (port16)
         lane_ok = (opt.lanes[1] & lane_up) | (opt.lanes[0] & lane_lo);
      else
         lane_ok = |opt.lanes;
   end

   always_comb begin
      dir_ok = bus_rd ? opt.dir[0] : opt.dir[1];
   end

   always_comb begin
      cpu_space = (bus_fc == FC_CPU);
      user_sp   = ~bus_fc[2];
      unique case (opt.space)
         SP_CPU:  space_ok = cpu_space;
         SP_USER: space_ok = ~cpu_space & user_sp;
         SP_SUPV: space_ok = ~cpu_space & ~user_sp;
         default: space_ok = ~cpu_space;
      endcase
   end

   always_comb begin
      if (opt.space == SP_CPU && opt.prio != '0)
         prio_ok = (bus_lvl == opt.prio);
      else
         prio_ok = 1'b1;
   end

   assign qual = addr_hit & lane_ok & dir_ok & space_ok & prio_ok;

endmodule

// File: rtl/csel_strobe.sv
module csel_strobe #(
   parameter bit SYNC_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual,
   input  logic bus_as,
   input  logic bus_ds,
   input  logic eclk_en,
   input  logic sync_mode,
   input  logic strb_ds,
   output logic cs
);
   logic trig;

   generate
      if (SYNC_EN) begin : g_sync
         always_comb begin
            if (sync_mode) trig = eclk_en;
            else           trig = strb_ds ? bus_ds : 1'b1;
         end
      end else begin : g_async_only
         always_comb trig = strb_ds ? bus_ds : 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)                       cs <= 1'b0;
      else if (!bus_as)                 cs <= 1'b0;
      else if (!cs && trig && qual)     cs <= 1'b1;
   end

   p_cs_needs_as_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cs |-> $past(bus_as));
   p_cs_rise_qual_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) |-> $past(qual));
   p_ds_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) && !$past(sync_mode) && $past(strb_ds) |-> $past(bus_ds));

   generate
      if (SYNC_EN) begin : g_sync_chk
         p_sync_eclk_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cs) && $past(sync_mode) |-> $past(eclk_en));
      end
   endgenerate

endmodule

// File: rtl/csel_ack.sv
module csel_ack #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic [CODE_W-1:0] code,
   output logic              dsack
);
   localparam logic [CODE_W-1:0] CODE_EXT  = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_FAST = CODE_EXT - 1'b1;
   localparam logic [CODE_W-1:0] CNT_MAX   = {CODE_W{1'b1}};

   generate
      if (CODE_W < 2) begin : g_bad_code
         $error("csel_ack: CODE_W must be at least 2");
      end
   endgenerate

   logic [CODE_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !cs)     cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   always_comb begin
      if (!cs)                    dsack = 1'b0;
      else if (code == CODE_FAST) dsack = 1'b1;
      else if (code == CODE_EXT)  dsack = 1'b0;
      else                        dsack = (cnt > code);
   end

   p_ack_needs_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dsack |-> cs);
   p_wait_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) && code != CODE_FAST |-> !dsack);
   p_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs) && code == CODE_FAST |-> dsack);
   p_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dsack) |-> code != CODE_EXT);

endmodule

// File: rtl/csel_unit.sv
module csel_unit #(
   parameter bit IS_BOOT = 1'b0,
   parameter bit SYNC_EN = 1'b1,
   parameter int FC_W    = 3,
   parameter int LVL_W   = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       opt_we,
   input  logic [csel_pkg::OPT_W-1:0] opt_wdata,
   input  logic                       bus_as,
   input  logic                       bus_ds,
   input  logic                       bus_rd,
   input  logic [FC_W-1:0]            bus_fc,
   input  logic                       bus_a0,
   input  logic                       bus_word,
   input  logic [LVL_W-1:0]           bus_lvl,
   input  logic                       port16,
   input  logic                       addr_hit,
   input  logic                       eclk_en,
   output logic                       cs_o,
   output logic                       dsack_o,
   output logic                       avec_o
);
   import csel_pkg::*;

   copt_t opt_q;
   logic  boot_pend;
   logic  qual, cpu_space;

   generate
      if (IS_BOOT) begin : g_boot
         always_ff @(posedge clk) begin
            if (!rst_n) boot_pend <= 1'b1;
            else        boot_pend <= 1'b0;
         end
         p_boot_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(boot_pend) |-> opt_q.lanes == 2'b11 && opt_q.dir == 2'b11);
      end else begin : g_general
         assign boot_pend = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         opt_q <= '0;
      end else if (boot_pend) begin
         opt_q.lanes <= 2'b11;
         opt_q.dir   <= 2'b11;
         opt_q.space <= SP_BOTH;
      end else if (opt_we) begin
         opt_q <= copt_t'(opt_wdata);
      end
   end

   csel_match #(.FC_W(FC_W), .LVL_W(LVL_W)) u_match (
      .opt       (opt_q),
      .bus_rd    (bus_rd),
      .bus_fc    (bus_fc),
      .bus_a0    (bus_a0),
      .bus_word  (bus_word),
      .bus_lvl   (bus_lvl),
      .port16    (port16),
      .addr_hit  (addr_hit),
      .cpu_space (cpu_space),
      .qual      (qual)
   );

   csel_strobe #(.SYNC_EN(SYNC_EN)) u_strobe (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual      (qual),
      .bus_as    (bus_as),
      .bus_ds    (bus_ds),
      .eclk_en   (eclk_en),
      .sync_mode (opt_q.sync_mode),
      .strb_ds   (opt_q.strb_ds),
      .cs        (cs_o)
   );

   csel_ack #(.CODE_W(ACK_W)) u_ack (
      .clk   (clk),
      .rst_n (rst_n),
      .cs    (cs_o),
      .code  (opt_q.ack),
      .dsack (dsack_o)
   );

   assign avec_o = cs_o & opt_q.avec & (opt_q.space == SP_CPU) & cpu_space;

   p_avec_with_cs_r13: assert property (@(posedge clk) disable iff (!rst_n)
      avec_o |-> cs_o && bus_fc == {FC_W{1'b1}});
   p_drop_on_as_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_as |=> !cs_o && !dsack_o);

endmodule

// File: tb/sim_csel_unit.sv
module sim_csel_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        opt_we = 1'b0;
   logic [15:0] opt_wdata = '0;
   logic        bus_as = 0, bus_ds = 0, bus_rd = 1, bus_a0 = 0, bus_word = 0;
   logic [2:0]  bus_fc = 3'd5, bus_lvl = 3'd0;
   logic        port16 = 1, addr_hit = 1, eclk_en = 0;
   logic        cs0, ack0, av0, cs1, ack1, av1;
   int          n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   csel_unit #(.IS_BOOT(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata),
      .bus_as(bus_as), .bus_ds(bus_ds), .bus_rd(bus_rd), .bus_fc(bus_fc),
      .bus_a0(bus_a0), .bus_word(bus_word), .bus_lvl(bus_lvl), .port16(port16),
      .addr_hit(addr_hit), .eclk_en(eclk_en),
      .cs_o(cs0), .dsack_o(ack0), .avec_o(av0));

   csel_unit #(.IS_BOOT(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .opt_we(1'b0), .opt_wdata(16'h0000),
      .bus_as(bus_as), .bus_ds(bus_ds), .bus_rd(bus_rd), .bus_fc(bus_fc),
      .bus_a0(bus_a0), .bus_word(bus_word), .bus_lvl(bus_lvl), .port16(port16),
      .addr_hit(addr_hit), .eclk_en(eclk_en),
      .cs_o(cs1), .dsack_o(ack1), .avec_o(av1));

   // option word: {avec, mode, strb, dir[2], lanes[2], space[2], prio[3], ack[4]}
   function automatic logic [15:0] mk(input logic av, input logic md, input logic sb,
                                      input logic [1:0] dr, input logic [1:0] ln,
                                      input logic [1:0] sp, input logic [2:0] pr,
                                      input logic [3:0] ak);
      return {av, md, sb, dr, ln, sp, pr, ak};
   endfunction

   typedef struct packed {
      logic [1:0] ln; logic [1:0] dr; logic [1:0] sp; logic [2:0] pr;
      logic [2:0] fc; logic rd; logic a0; logic wd; logic p16;
      logic [2:0] lvl; logic hit; logic exp; logic [3:0] req;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VT [NV] = '{
      '{2'b11,2'b11,2'b11,3'd0,3'd5,1'b1,1'b0,1'b0,1'b1,3'd0,1'b1,1'b1,4'd2},  // R2 both lanes
      '{2'b01,2'b11,2'b11,3'd0,3'd5,1'b1,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,4'd2},  // R2 lower lane, even byte
      '{2'b01,2'b11,2'b11,3'd0,3'd5,1'b1,1'b1,1'b0,1'b1,3'd0,1'b1,1'b1,4'd2},  // R2 lower lane, odd byte
      '{2'b10,2'b11,2'b11,3'd0,3'd5,1'b1,1'b1,1'b0,1'b1,3'd0,1'b1,1'b0,4'd2},  // R2 upper lane, odd byte
      '{2'b10,2'b11,2'b11,3'd0,3'd5,1'b1,1'b1,1'b1,1'b1,3'd0,1'b1,1'b1,4'd2},  // R2 upper lane, word
      '{2'b01,2'b11,2'b11,3'd0,3'd5,1'b1,1'b0,1'b0,1'b0,3'd0,1'b1,1'b1,4'd3},  // R3 8-bit any lane
      '{2'b00,2'b11,2'b11,3'd0,3'd5,1'b1,1'b0,1'b0,1'b0,3'd0,1'b1,1'b0,4'd3},  // R3 8-bit disabled
      '{2'b11,2'b01,2'b11,3'd0,3'd5,1'b0,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,4'd4},  // R4 read-only, write
      '{2'b11,2'b10,2'b11,3'd0,3'd5,1'b0,1'b0,1'b0,1'b1,3'd0,1'b1,1'b1,4'd4},  // R4 write-only, write
      '{2'b11,2'b00,2'b11,3'd0,3'd5,1'b1,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,4'd4},  // R4 reserved
      '{2'b11,2'b11,2'b01,3'd0,3'd5,1'b1,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,4'd5},  // R5 user vs supv
      '{2'b11,2'b11,2'b10,3'd0,3'd5,1'b1,1'b0,1'b0,1'b1,3'd0,1'b1,1'b1,4'd5},  // R5 supv
      '{2'b11,2'b11,2'b01,3'd0,3'd1,1'b1,1'b0,1'b0,1'b1,3'd0,1'b1,1'b1,4'd5},  // R5 user
      '{2'b11,2'b11,2'b00,3'd0,3'd5,1'b1,1'b0,1'b0,1'b1,3'd0,1'b1,1'b0,4'd5},  // R5 cpu vs supv
      '{2'b11,2'b11,2'b00,3'd0,3'd7,1'b1,1'b0,1'b0,1'b1,3'd3,1'b1,1'b1,4'd6},  // R6 any level
      '{2'b11,2'b11,2'b00,3'd3,3'd7,1'b1,1'b0,1'b0,1'b1,3'd3,1'b1,1'b1,4'd6},  // R6 equal level
      '{2'b11,2'b11,2'b00,3'd4,3'd7,1'b1,1'b0,1'b0,1'b1,3'd3,1'b1,1'b0,4'd6},  // R6 other level
      '{2'b11,2'b11,2'b11,3'd0,3'd5,1'b1,1'b0,1'b0,1'b1,3'd0,1'b0,1'b0,4'd2}   // R2 no address hit
   };

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
   endtask

   task automatic chk_int(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] w);
      @(negedge clk); opt_we = 1'b1; opt_wdata = w;
      @(negedge clk); opt_we = 1'b0;
   endtask

   task automatic idle();
      bus_as = 0; bus_ds = 0; eclk_en = 0;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic set_bus(input logic [2:0] fc, input logic rd, input logic a0,
                          input logic wd, input logic p16, input logic [2:0] lv,
                          input logic hit);
      bus_fc = fc; bus_rd = rd; bus_a0 = a0; bus_word = wd;
      port16 = p16; bus_lvl = lv; addr_hit = hit;
   endtask

   // counts negedges from strobe until dsack_o first seen; 0 if never
   task automatic meas(input logic [15:0] w, input int lim, output int k);
      wr(w);
      set_bus(3'd5, 1, 0, 0, 1, 0, 1);
      bus_as = 1; bus_ds = 1; k = 0;
      for (int i = 1; i <= lim; i++) begin
         @(negedge clk);
         if (ack0) begin k = i; break; end
      end
   endtask

   int k;

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            chk(cs0, 0, "R1 cs in reset");
            chk(ack0, 0, "R1 dsack in reset");
            chk(av0, 0, "R1 avec in reset");
            rst_n = 1;
            @(negedge clk); @(negedge clk);
            // R1: general channel disabled, boot channel live
            set_bus(3'd5, 1, 0, 0, 1, 0, 1);
            bus_as = 1; bus_ds = 1;
            @(negedge clk);
            chk(cs0, 0, "R1 general channel after reset");
            chk(cs1, 1, "R1 boot channel after reset");
            chk(ack1, 0, "R1 boot dsack first cycle");
            @(negedge clk);
            chk(ack1, 1, "R1 boot dsack one wait");
            idle();

            // R14 option layout exercised by every vector; R2..R6 qualification
            for (int i = 0; i < NV; i++) begin
               wr(mk(0, 0, 0, VT[i].dr, VT[i].ln, VT[i].sp, VT[i].pr, 4'd14));
               set_bus(VT[i].fc, VT[i].rd, VT[i].a0, VT[i].wd, VT[i].p16,
                       VT[i].lvl, VT[i].hit);
               bus_as = 1; bus_ds = 1;
               @(negedge clk);
               chk(cs0, VT[i].exp, $sformatf("R%0d R14 vector %0d", VT[i].req, i));
               idle();
            end

            // R7 data strobe timing
            wr(mk(0, 0, 1, 2'b11, 2'b11, 2'b11, 0, 4'd14));
            set_bus(3'd5, 1, 0, 0, 1, 0, 1);
            bus_as = 1; bus_ds = 0;
            @(negedge clk); @(negedge clk);
            chk(cs0, 0, "R7 waits for ds");
            bus_ds = 1;
            @(negedge clk);
            chk(cs0, 1, "R7 asserts with ds");
            idle();

            // R8 synchronous mode ignores strobe bit, waits for eclk_en
            wr(mk(0, 1, 1, 2'b11, 2'b11, 2'b11, 0, 4'd14));
            bus_as = 1; bus_ds = 0;
            @(negedge clk); @(negedge clk);
            chk(cs0, 0, "R8 no eclk pulse");
            eclk_en = 1;
            @(negedge clk); eclk_en = 0;
            chk(cs0, 1, "R8 asserts on eclk pulse");
            idle();

            // R9 wait counts
            meas(mk(0, 0, 0, 2'b11, 2'b11, 2'b11, 0, 4'd0), 20, k);
            chk_int(k, 2, "R9 zero wait");
            idle();
            meas(mk(0, 0, 0, 2'b11, 2'b11, 2'b11, 0, 4'd3), 20, k);
            chk_int(k, 5, "R9 three waits");
            @(negedge clk);
            chk(ack0, 1, "R9 dsack held");
            // R12 negation
            bus_as = 0; bus_ds = 0;
            @(negedge clk);
            chk(cs0, 0, "R12 cs drops with as");
            chk(ack0, 0, "R12 dsack drops with as");
            idle();
            meas(mk(0, 0, 0, 2'b11, 2'b11, 2'b11, 0, 4'd13), 20, k);
            chk_int(k, 15, "R9 thirteen waits");
            idle();

            // R10 fast termination
            meas(mk(0, 0, 0, 2'b11, 2'b11, 2'b11, 0, 4'd14), 20, k);
            chk_int(k, 1, "R10 fast termination");
            chk(cs0, 1, "R10 cs with fast ack");
            idle();

            // R11 external acknowledge
            meas(mk(0, 0, 0, 2'b11, 2'b11, 2'b11, 0, 4'd15), 20, k);
            chk_int(k, 0, "R11 no internal dsack");
            chk(cs0, 1, "R11 cs still held");
            idle();

            // R13 autovector
            wr(mk(1, 0, 0, 2'b11, 2'b11, 2'b00, 0, 4'd14));
            set_bus(3'd7, 1, 0, 0, 1, 3'd2, 1);
            bus_as = 1; bus_ds = 1;
            @(negedge clk);
            chk(av0, 1, "R13 avec in cpu space");
            idle();
            wr(mk(0, 0, 0, 2'b11, 2'b11, 2'b00, 0, 4'd14));
            bus_as = 1; bus_ds = 1;
            @(negedge clk);
            chk(cs0, 1, "R13 cs without avec bit");
            chk(av0, 0, "R13 avec bit clear");
            idle();
            wr(mk(1, 0, 0, 2'b11, 2'b11, 2'b11, 0, 4'd14));
            set_bus(3'd5, 1, 0, 0, 1, 0, 1);
            bus_as = 1; bus_ds = 1;
            @(negedge clk);
            chk(av0, 0, "R13 no avec outside cpu space");
            idle();
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule